// File: doc/BRIEF.md
# Multi-channel prescaled PWM controller

This block is a register-mapped pulse-width modulator with up to eight channels. A 32-bit register bus writes and reads the configuration: address, write enable and write data go in, and read data comes back combinationally in the same cycle. Each channel has its own window of three registers: a control word with a divider field and a mode bit, a 13-bit period value and a 13-bit duty threshold. One shared register holds an enable bit for each channel. Software updates that register by read-modify-write, so it can be read back.

Each enabled channel first divides its counting clock by a power of two. It then steps a period counter from zero up to the period value and wraps back to zero. The channel output is high while the counter is below the threshold. New period and threshold values wait in the registers and are copied into the running channel only when its counter wraps, so a change made mid-period never cuts a pulse short.

A clock-select register picks what drives the counting. It is either every bus-clock cycle or a one-cycle enable pulse from an alternate reference input.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads 0 and every output is low. The enable register at address 0x000 holds bit n for channel n and reads back the value last written.
- R2: The register window of channel n starts at 0x010 + 0x40*n for n = 0..6, and at 0x220 for channel 7. Within a window the control word sits at +0x00, with bits 2:0 as the divider and bit 15 as the mode bit. The period sits at +0x2C and the threshold at +0x30, both 13 bits wide. Bits outside these fields read as 0.
- R3: A read from any address not listed in R1, R2 or R9 returns 0. A write to such an address changes no register.
- R4: In an enabled channel the counter is 0 in the first cycle after the enable is written. It advances once per channel tick and wraps from the period value P to 0. The output is high exactly while the counter is below the threshold T.
- R5: A threshold of 0 keeps the output low. A threshold above P keeps it high.
- R6: With divider value d, a channel tick occurs once every 2^d counting-clock enables.
- R7: Period and threshold values written while a channel runs take effect only at that channel's next wrap.
- R8: While a channel's enable bit is 0, its prescaler and counter are held at 0 and its output is low. Enabling it again restarts its waveform from counter 0.
- R9: Writing 0 to the clock-select register at 0x210 makes every bus-clock cycle a counting enable. Writing any nonzero value makes only cycles with alt_tick high count. The register reads 1 when nonzero.
- R10: An enabled channel whose control-word mode bit 15 is 0 drives its output low.
- R11: Changing one channel's enable bit or registers does not disturb the waveform of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 10 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| alt_tick | input | 1 | Counting enable from the alternate reference |
| pwm_out | output | 8 | One waveform output per channel |

## Verification
The hardest case to reach is a period and threshold rewrite that lands in the middle of a running period. The stimulus starts a channel with a long period and writes the new values a few cycles later on exact edges. The expected output keeps the old waveform up to the wrap and switches to the new one afterwards. Channel independence is covered by clearing one enable bit while a second channel keeps counting. The alternate clock source is checked by holding alt_tick low, where the counter must stay frozen, and then giving it single-cycle pulses.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
    localparam int AW       = 10;
    localparam int DW       = 32;
    localparam int PER_W    = 13;
    localparam int DIV_W    = 3;
    localparam int PRE_W    = (1 << DIV_W) - 1;
    localparam int MAX_CH   = 8;
    localparam int MODE_BIT = 15;

    localparam logic [AW-1:0] ADDR_EN   = 10'h000;
    localparam logic [AW-1:0] ADDR_CSEL = 10'h210;
    localparam logic [AW-1:0] OFS_CTRL  = 10'h000;
    localparam logic [AW-1:0] OFS_PER   = 10'h02C;
    localparam logic [AW-1:0] OFS_THR   = 10'h030;

    typedef struct packed {
        logic             mode;
        logic [DIV_W-1:0] div;
        logic [PER_W-1:0] per;
        logic [PER_W-1:0] thr;
    } chan_cfg_t;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [PER_W-1:0] cnt;
        logic [PER_W-1:0] per;
        logic [PER_W-1:0] thr;
    } chan_st_t;

    // Start address of a channel's register window; the last channel is relocated.
    function automatic logic [AW-1:0] win_base(input int n);
        if (n < MAX_CH - 1) return AW'(16 + 64 * n);
        else                return AW'(544);
    endfunction
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         addr,
    input  logic                  we,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         rdata,
    output logic [NCH-1:0]        en,
    output logic                  csel,
    output chan_cfg_t [NCH-1:0]   cfg
);
    typedef struct packed {
        logic [NCH-1:0]      en;
        logic                csel;
        chan_cfg_t [NCH-1:0] cfg;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            if (addr == ADDR_EN)   st_d.en   = wdata[NCH-1:0];
            if (addr == ADDR_CSEL) st_d.csel = |wdata;
            for (int n = 0; n < NCH; n++) begin
                if (addr == win_base(n) + OFS_CTRL) begin
                    st_d.cfg[n].mode = wdata[MODE_BIT];
                    st_d.cfg[n].div  = wdata[DIV_W-1:0];
                end
                if (addr == win_base(n) + OFS_PER) st_d.cfg[n].per = wdata[PER_W-1:0];
                if (addr == win_base(n) + OFS_THR) st_d.cfg[n].thr = wdata[PER_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_EN)   rdata[NCH-1:0] = st_q.en;
        if (addr == ADDR_CSEL) rdata[0]       = st_q.csel;
        for (int n = 0; n < NCH; n++) begin
            if (addr == win_base(n) + OFS_CTRL) begin
                rdata[MODE_BIT]    = st_q.cfg[n].mode;
                rdata[DIV_W-1:0]   = st_q.cfg[n].div;
            end
            if (addr == win_base(n) + OFS_PER) rdata[PER_W-1:0] = st_q.cfg[n].per;
            if (addr == win_base(n) + OFS_THR) rdata[PER_W-1:0] = st_q.cfg[n].thr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en   = st_q.en;
    assign csel = st_q.csel;
    assign cfg  = st_q.cfg;
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
    import pwm_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             base_tick,
    input  chan_cfg_t        cfg,
    output logic             out,
    output logic [PER_W-1:0] cnt,
    output logic [PER_W-1:0] per_act,
    output logic [PER_W-1:0] thr_act
);
    chan_st_t         st_d, st_q;
    logic [PRE_W:0]   lim_full;
    logic [PRE_W-1:0] pre_lim;
    logic             tick;

    always_comb begin
        st_d     = st_q;
        lim_full = ((PRE_W+1)'(1) << cfg.div) - (PRE_W+1)'(1);
        pre_lim  = lim_full[PRE_W-1:0];
        tick     = 1'b0;
        if (!en) begin
            // idle: hold counting state at zero and track the programmed values
            st_d.pre = '0;
            st_d.cnt = '0;
            st_d.per = cfg.per;
            st_d.thr = cfg.thr;
        end else if (base_tick) begin
            if (st_q.pre >= pre_lim) begin
                st_d.pre = '0;
                tick     = 1'b1;
            end else begin
                st_d.pre = st_q.pre + PRE_W'(1);
            end
            if (tick) begin
                if (st_q.cnt >= st_q.per) begin
                    st_d.cnt = '0;
                    st_d.per = cfg.per;
                    st_d.thr = cfg.thr;
                end else begin
                    st_d.cnt = st_q.cnt + PER_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out     = en && cfg.mode && (st_q.cnt < st_q.thr);
    assign cnt     = st_q.cnt;
    assign per_act = st_q.per;
    assign thr_act = st_q.thr;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_we,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic           alt_tick,
    output logic [NCH-1:0] pwm_out
);
    logic [NCH-1:0]            en_vec;
    logic                      csel;
    chan_cfg_t [NCH-1:0]       cfg;
    logic                      base_tick;
    logic [NCH-1:0][PER_W-1:0] cnt_all;
    logic [NCH-1:0][PER_W-1:0] per_all;
    logic [NCH-1:0][PER_W-1:0] thr_all;

    pwm_bank_regs #(.NCH(NCH)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .we    (bus_we),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .en    (en_vec),
        .csel  (csel),
        .cfg   (cfg)
    );

    assign base_tick = csel ? alt_tick : 1'b1;

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        pwm_bank_chan u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (en_vec[n]),
            .base_tick (base_tick),
            .cfg       (cfg[n]),
            .out       (pwm_out[n]),
            .cnt       (cnt_all[n]),
            .per_act   (per_all[n]),
            .thr_act   (thr_all[n])
        );
    end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
    import pwm_bank_pkg::*;
#(
    parameter int NCH = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [AW-1:0]             bus_addr,
    input logic [DW-1:0]             bus_rdata,
    input logic [NCH-1:0]            en_vec,
    input logic [NCH-1:0]            pwm_out,
    input logic [NCH-1:0][PER_W-1:0] cnt_all,
    input logic [NCH-1:0][PER_W-1:0] per_all,
    input logic [NCH-1:0][PER_W-1:0] thr_all
);
    a_r3_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 10'h004) |-> (bus_rdata == '0));

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_all[n] <= per_all[n]);

        a_r5_thr_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_all[n] == '0) |-> !pwm_out[n]);

        a_r7_shadow_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(en_vec[n]) && !$stable(per_all[n])) |-> ($past(cnt_all[n]) == $past(per_all[n])));

        a_r8_off_low: assert property (@(posedge clk) disable iff (!rst_n)
            !en_vec[n] |-> !pwm_out[n]);

        a_r8_off_cnt_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(en_vec[n]) |-> (cnt_all[n] == '0));
    end
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .en_vec    (en_vec),
    .pwm_out   (pwm_out),
    .cnt_all   (cnt_all),
    .per_all   (per_all),
    .thr_all   (thr_all)
);

// File: tb/pwm_bank_test.sv
module pwm_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [9:0]     bus_addr = '0;
    logic           bus_we = 1'b0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic           alt_tick = 1'b0;
    logic [NCH-1:0] pwm_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [NCH-1:0] exp_q[$];
    string          tag_q[$];

    pwm_bank #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_tick(alt_tick),
        .pwm_out(pwm_out)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] wbase(input int n);
        return (n == 7) ? 10'h220 : 10'(16 + 64 * n);
    endfunction

    function automatic bit wave(input int p, input int t, input int d, input int j);
        int c;
        c = (j >> d) % (p + 1);
        return c < t;
    endfunction

    // all bus tasks start at a falling edge and return at the next one
    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0; bus_addr = '0;
    endtask

    task automatic chk_rd(input string tag, input logic [9:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_addr = a;
        #1 v = bus_rdata;
        chk(tag, v, exp);
        @(negedge clk);
        bus_addr = '0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic cfg_ch(input int n, input logic [31:0] ctrl, input logic [31:0] per, input logic [31:0] thr);
        wr(wbase(n), ctrl);
        wr(wbase(n) + 10'h2C, per);
        wr(wbase(n) + 10'h30, thr);
    endtask

    task automatic push(input string tag, input logic [NCH-1:0] v);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    // scoreboard monitor: one expected output vector per cycle
    initial forever begin
        @(posedge clk);
        #2;
        if (exp_q.size() > 0) begin
            logic [NCH-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, {24'b0, pwm_out}, {24'b0, e});
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 outputs low after reset", {24'b0, pwm_out}, 32'h0);
        chk_rd("R1 enable reg resets to 0", 10'h000, 32'h0);
        chk_rd("R1 period reg resets to 0", wbase(3) + 10'h2C, 32'h0);
        wr(10'h000, 32'hA5);
        chk_rd("R1 enable readback", 10'h000, 32'hA5);
        wr(10'h000, 32'h0);

        // R2 field widths and window placement
        wr(wbase(2), 32'hFFFF_FFFF);
        chk_rd("R2 control readback fields", wbase(2), 32'h0000_8007);
        wr(wbase(2) + 10'h2C, 32'hFFFF_FFFF);
        chk_rd("R2 period is 13 bits", wbase(2) + 10'h2C, 32'h0000_1FFF);
        wr(wbase(7) + 10'h30, 32'h0000_1234);
        chk_rd("R2 relocated window threshold", 10'h250, 32'h0000_1234);
        wr(10'h210, 32'h5);
        chk_rd("R9 clock select reads 1 when nonzero", 10'h210, 32'h1);
        wr(10'h210, 32'h0);
        chk_rd("R9 clock select reads 0", 10'h210, 32'h0);

        // R3 unmapped addresses
        cfg_ch(0, 32'h8003, 32'h0AA, 32'h055);
        wr(10'h004, 32'hFFFF_FFFF);
        wr(10'h014, 32'hFFFF_FFFF);
        chk_rd("R3 unmapped read 0x004", 10'h004, 32'h0);
        chk_rd("R3 unmapped read 0x014", 10'h014, 32'h0);
        chk_rd("R3 unmapped read 0x3FC", 10'h3FC, 32'h0);
        chk_rd("R3 ch0 control untouched", wbase(0), 32'h8003);
        chk_rd("R3 ch0 period untouched", wbase(0) + 10'h2C, 32'h0AA);
        chk_rd("R3 ch0 threshold untouched", wbase(0) + 10'h30, 32'h055);
        chk_rd("R3 enable untouched", 10'h000, 32'h0);

        // R4 R6 R11 two channels, then ch0 dropped while ch1 continues
        cfg_ch(0, 32'h8000, 32'd4, 32'd2);
        cfg_ch(1, 32'h8002, 32'd3, 32'd2);
        for (int j = 0; j < 40; j++) begin
            logic [NCH-1:0] v;
            v = '0;
            v[0] = (j < 20) ? wave(4, 2, 0, j) : 1'b0;
            v[1] = wave(3, 2, 2, j);
            push("R4 R6 R11 waveform", v);
        end
        wr(10'h000, 32'h3);
        idle(19);
        wr(10'h000, 32'h2);
        drain();
        wr(10'h000, 32'h0);

        // R5 threshold extremes
        cfg_ch(2, 32'h8000, 32'd5, 32'd0);
        cfg_ch(3, 32'h8000, 32'd5, 32'd7);
        for (int j = 0; j < 16; j++) push("R5 threshold 0 low, above period high", 8'h08);
        wr(10'h000, 32'hC);
        drain();
        wr(10'h000, 32'h0);

        // R7 rewrite mid-period
        cfg_ch(0, 32'h8000, 32'd9, 32'd3);
        for (int j = 0; j < 25; j++) begin
            logic [NCH-1:0] v;
            v = '0;
            v[0] = (j < 10) ? wave(9, 3, 0, j) : wave(4, 2, 0, j - 10);
            push("R7 new values at wrap", v);
        end
        wr(10'h000, 32'h1);
        idle(2);
        wr(wbase(0) + 10'h2C, 32'd4);
        wr(wbase(0) + 10'h30, 32'd2);
        drain();

        // R8 disable forces low, re-enable restarts at counter 0
        for (int j = 0; j < 6; j++) push("R8 disabled low", 8'h00);
        wr(10'h000, 32'h0);
        drain();
        for (int j = 0; j < 15; j++) push("R8 restart from zero", {7'b0, wave(4, 2, 0, j)});
        wr(10'h000, 32'h1);
        drain();
        wr(10'h000, 32'h0);

        // R9 alternate counting enable
        cfg_ch(4, 32'h8000, 32'd1, 32'd1);
        wr(10'h210, 32'h5);
        for (int j = 0; j < 6; j++) push("R9 no alt pulse, counter frozen", 8'h10);
        wr(10'h000, 32'h10);
        drain();
        alt_tick = 1'b1;
        @(negedge clk);
        alt_tick = 1'b0;
        chk("R9 first alt pulse advances", {31'b0, pwm_out[4]}, 32'h0);
        @(negedge clk);
        chk("R9 idle alt holds", {31'b0, pwm_out[4]}, 32'h0);
        alt_tick = 1'b1;
        @(negedge clk);
        alt_tick = 1'b0;
        chk("R9 second alt pulse wraps", {31'b0, pwm_out[4]}, 32'h1);
        for (int j = 0; j < 8; j++) push("R9 bus clock counting", (j % 2 == 0) ? 8'h10 : 8'h00);
        wr(10'h210, 32'h0);
        drain();
        wr(10'h000, 32'h0);

        // R10 mode bit clear
        cfg_ch(5, 32'h0000, 32'd3, 32'd2);
        for (int j = 0; j < 8; j++) push("R10 mode off stays low", 8'h00);
        wr(10'h000, 32'h20);
        drain();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule